// File: doc/BRIEF.md
# PHY Discovery and Autonegotiation Sequencer

This block brings up an Ethernet PHY through a management (MDIO) master that it drives over a simple request/acknowledge port. A one-cycle `start` pulse begins the sequence. The block scans management addresses from 0 upward and picks the first PHY that answers. It then resets that PHY and waits for the reset to finish, clears the isolate bit, and advertises 10 and 100 Mb/s operation at both half and full duplex. Last, it restarts autonegotiation and waits until the link is up.

Wait intervals are counted in pulses of `tick`, a timebase input such as a 1 µs strobe. Each polling loop has its own spacing and its own bound, both set by parameters. When the sequence ends, the block raises `done` and holds it. At that point it reports the selected address, the last status word, the partner's ability word, and flags that say how the sequence ended. It does not decode speed or duplex from those words.

Top module: `phy_autoneg_seq`

## Requirements
- R1: Addresses are scanned in ascending order from 0. At each address the block reads register 0, then register 1. The first address where neither value equals 16'hFFFF is selected and shown on `phy_addr`. An address where only one of the two reads is 16'hFFFF is skipped.
- R2: If address 31 is scanned and nothing has answered, the block sets `fail_nophy` and `done` and issues no write. At most one of `fail_nophy`, `fail_died` and `an_timeout` is ever set.
- R3: Reset of the selected PHY is a read of register 0, followed by a write to register 0 of the value just read with bit 15 set.
- R4: After the reset write, register 0 is polled once every `RST_TICKS` pulses of `tick`, and never while `tick` stays low. A poll that returns 16'hFFFF ends the sequence with `fail_died` and `done` set.
- R5: If bit 15 is still set after `RST_POLLS` polls, the block sets `rst_timeout` and continues with the isolate-clear step.
- R6: The isolate-clear step writes register 0 with the last polled value, bit 10 cleared.
- R7: Every status fetch reads register 1 twice in a row. `bmsr_word` takes the bitwise OR of the two values.
- R8: After a status fetch that follows the isolate-clear step, the block writes 16'h01E1 to register 4 and then 16'h1200 to register 0.
- R9: Status is then fetched at once, and again after every further `AN_TICKS` ticks, until the ORed word has bit 2 (link) and bit 5 (negotiation complete) both set. If `AN_POLLS` fetches pass without that, the block sets `an_timeout` and `done`, and `lpa_word` stays 0.
- R10: When link and completion are both seen, the block reads register 5 into `lpa_word` and sets `done`.
- R11: `mdio_req` and its fields hold steady until `mdio_ack` is sampled high. Each cycle with both `mdio_req` and `mdio_ack` high completes one transaction.
- R12: After reset, all outputs are 0. A `start` pulse in idle clears every result output and flag. `mdio_req` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the sequence (accepted in idle) |
| tick | input | 1 | Timebase strobe for wait intervals |
| mdio_req | output | 1 | Management transaction request |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | Target PHY address |
| mdio_reg | output | 5 | Target register number |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | Transaction complete |
| mdio_rdata | input | 16 | Read data, valid with `mdio_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence ended (any outcome) |
| phy_addr | output | 5 | Selected PHY address |
| bmsr_word | output | 16 | Latest ORed status word |
| lpa_word | output | 16 | Link-partner ability word |
| fail_nophy | output | 1 | No PHY answered |
| fail_died | output | 1 | PHY read all-ones during reset |
| rst_timeout | output | 1 | Reset poll bound exhausted |
| an_timeout | output | 1 | Autonegotiation bound exhausted |

## Verification
The bench runs a behavioural PHY that splits link and negotiation-complete across the two status reads. A design that uses only one read of the pair never reaches link, so it times out and reports a zero partner word. Decoy addresses where only one register answers must be skipped; a test that checks only one register would select the decoy. A PHY that never leaves reset must still be driven on to the isolate write, with bit 15 still in the written value. A PHY that dies must stop the sequence before any advertisement write. With `tick` held low the reset poll must not start, so a design that polls on the clock alone shows up at once.

// File: rtl/phy_autoneg_seq.sv
module phy_autoneg_seq #(
  parameter int RST_TICKS = 10,
  parameter int RST_POLLS = 100,
  parameter int AN_TICKS  = 10000,
  parameter int AN_POLLS  = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        tick,
  output logic        mdio_req,
  output logic        mdio_wr,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  output logic [15:0] mdio_wdata,
  input  logic        mdio_ack,
  input  logic [15:0] mdio_rdata,
  output logic        busy,
  output logic        done,
  output logic [4:0]  phy_addr,
  output logic [15:0] bmsr_word,
  output logic [15:0] lpa_word,
  output logic        fail_nophy,
  output logic        fail_died,
  output logic        rst_timeout,
  output logic        an_timeout
);
  localparam int MAXT = (RST_TICKS > AN_TICKS) ? RST_TICKS : AN_TICKS;
  localparam int MAXP = (RST_POLLS > AN_POLLS) ? RST_POLLS : AN_POLLS;
  localparam int TW = $clog2(MAXT) + 1;
  localparam int PW = $clog2(MAXP) + 1;
  localparam logic [TW-1:0] RT_LAST = TW'(RST_TICKS - 1);
  localparam logic [TW-1:0] AT_LAST = TW'(AN_TICKS - 1);
  localparam logic [PW-1:0] RP_LAST = PW'(RST_POLLS - 1);
  localparam logic [PW-1:0] AP_LAST = PW'(AN_POLLS - 1);

  typedef enum logic [4:0] {
    S_IDLE, S_SCAN_C, S_SCAN_S, S_RST_RD, S_RST_WR, S_RST_WAIT, S_RST_POLL,
    S_ISO_WR, S_ST1, S_ST2, S_ADV_WR, S_AN_WR, S_AN1, S_AN2, S_AN_WAIT, S_LPA
  } state_t;

  state_t          state;
  logic [15:0]     ctl_q, sts_q;
  logic [TW-1:0]   tick_cnt;
  logic [PW-1:0]   poll_cnt;

  wire        xfer   = mdio_req && mdio_ack;
  wire [15:0] sts_or = sts_q | mdio_rdata;
  wire        linked = sts_or[2] && sts_or[5];

  assign busy     = (state != S_IDLE);
  assign mdio_phy = phy_addr;

  always_comb begin
    mdio_req   = 1'b1;
    mdio_wr    = 1'b0;
    mdio_reg   = 5'd0;
    mdio_wdata = 16'h0000;
    case (state)
      S_SCAN_C, S_RST_RD, S_RST_POLL: mdio_reg = 5'd0;
      S_SCAN_S, S_ST1, S_ST2, S_AN1, S_AN2: mdio_reg = 5'd1;
      S_RST_WR: begin mdio_wr = 1'b1; mdio_wdata = ctl_q | 16'h8000; end
      S_ISO_WR: begin mdio_wr = 1'b1; mdio_wdata = ctl_q & ~16'h0400; end
      S_ADV_WR: begin mdio_wr = 1'b1; mdio_reg = 5'd4; mdio_wdata = 16'h01E1; end
      S_AN_WR:  begin mdio_wr = 1'b1; mdio_wdata = 16'h1200; end
      S_LPA:    mdio_reg = 5'd5;
      default:  mdio_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ctl_q <= '0; sts_q <= '0; tick_cnt <= '0; poll_cnt <= '0;
      done <= 1'b0; phy_addr <= '0; bmsr_word <= '0; lpa_word <= '0;
      fail_nophy <= 1'b0; fail_died <= 1'b0; rst_timeout <= 1'b0; an_timeout <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done <= 1'b0; phy_addr <= '0; bmsr_word <= '0; lpa_word <= '0;
          fail_nophy <= 1'b0; fail_died <= 1'b0; rst_timeout <= 1'b0; an_timeout <= 1'b0;
          state <= S_SCAN_C;
        end
        S_SCAN_C: if (xfer) begin ctl_q <= mdio_rdata; state <= S_SCAN_S; end
        S_SCAN_S: if (xfer) begin
          if (ctl_q != 16'hFFFF && mdio_rdata != 16'hFFFF) state <= S_RST_RD;
          else if (phy_addr == 5'd31) begin
            fail_nophy <= 1'b1; done <= 1'b1; state <= S_IDLE;
          end else begin
            phy_addr <= phy_addr + 5'd1; state <= S_SCAN_C;
          end
        end
        S_RST_RD: if (xfer) begin ctl_q <= mdio_rdata; state <= S_RST_WR; end
        S_RST_WR: if (xfer) begin
          tick_cnt <= '0; poll_cnt <= '0; state <= S_RST_WAIT;
        end
        S_RST_WAIT: if (tick) begin
          if (tick_cnt == RT_LAST) begin tick_cnt <= '0; state <= S_RST_POLL; end
          else tick_cnt <= tick_cnt + 1'b1;
        end
        S_RST_POLL: if (xfer) begin
          ctl_q    <= mdio_rdata;
          poll_cnt <= poll_cnt + 1'b1;
          if (mdio_rdata == 16'hFFFF) begin
            fail_died <= 1'b1; done <= 1'b1; state <= S_IDLE;
          end else if (!mdio_rdata[15]) state <= S_ISO_WR;
          else if (poll_cnt == RP_LAST) begin
            rst_timeout <= 1'b1; state <= S_ISO_WR;
          end else state <= S_RST_WAIT;
        end
        S_ISO_WR: if (xfer) state <= S_ST1;
        S_ST1:    if (xfer) begin sts_q <= mdio_rdata; state <= S_ST2; end
        S_ST2:    if (xfer) begin bmsr_word <= sts_or; state <= S_ADV_WR; end
        S_ADV_WR: if (xfer) state <= S_AN_WR;
        S_AN_WR:  if (xfer) begin poll_cnt <= '0; state <= S_AN1; end
        S_AN1:    if (xfer) begin sts_q <= mdio_rdata; state <= S_AN2; end
        S_AN2: if (xfer) begin
          bmsr_word <= sts_or;
          poll_cnt  <= poll_cnt + 1'b1;
          if (linked) state <= S_LPA;
          else if (poll_cnt == AP_LAST) begin
            an_timeout <= 1'b1; done <= 1'b1; state <= S_IDLE;
          end else begin
            tick_cnt <= '0; state <= S_AN_WAIT;
          end
        end
        S_AN_WAIT: if (tick) begin
          if (tick_cnt == AT_LAST) begin tick_cnt <= '0; state <= S_AN1; end
          else tick_cnt <= tick_cnt + 1'b1;
        end
        S_LPA: if (xfer) begin lpa_word <= mdio_rdata; done <= 1'b1; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req && !mdio_ack |=> mdio_req && $stable(mdio_reg) && $stable(mdio_wr)
      && $stable(mdio_wdata) && $stable(mdio_phy)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_req); // R12
  AST_ONE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fail_nophy, fail_died, an_timeout})); // R2
  AST_LPA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    an_timeout |-> lpa_word == 16'h0000); // R9
  AST_LINK_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail_nophy && !fail_died && !an_timeout |-> bmsr_word[2] && bmsr_word[5]); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R12
endmodule

// File: tb/phy_autoneg_seq_bench.sv
module phy_autoneg_seq_bench;
  localparam int RT = 2, RP = 4, AT = 3, AP = 5;
  localparam int NV = 8;
  // fields: addr (32 = none), decoy addr (40 = none), reset-busy polls, link pair, dies, partner word
  localparam int VEC [NV][6] = '{
    '{0,  40, 1,  0,  0, 16'h45E1},
    '{17, 40, 3,  2,  0, 16'h41E1},
    '{31, 40, 0,  1,  0, 16'hC5E1},
    '{32, 2,  0,  0,  0, 16'h0000},
    '{5,  40, 1,  0,  1, 16'h0000},
    '{4,  40, 99, 0,  0, 16'h05E1},
    '{6,  40, 0,  99, 0, 16'h1111},
    '{9,  3,  2,  3,  0, 16'h4DE1}
  };

  logic clk = 0, rst_n = 0, start = 0, tick = 0, mdio_ack = 0;
  logic [15:0] mdio_rdata = 0;
  logic mdio_req, mdio_wr, busy, done, fail_nophy, fail_died, rst_timeout, an_timeout;
  logic [4:0] mdio_phy, mdio_reg, phy_addr;
  logic [15:0] mdio_wdata, bmsr_word, lpa_word;
  always #10 clk = ~clk;

  phy_autoneg_seq #(.RST_TICKS(RT), .RST_POLLS(RP), .AN_TICKS(AT), .AN_POLLS(AP)) u_phy_autoneg_seq (
    .clk, .rst_n, .start, .tick, .mdio_req, .mdio_wr, .mdio_phy, .mdio_reg, .mdio_wdata,
    .mdio_ack, .mdio_rdata, .busy, .done, .phy_addr, .bmsr_word, .lpa_word,
    .fail_nophy, .fail_died, .rst_timeout, .an_timeout);

  int tests = 0, fails = 0;
  int sc_addr = 40, sc_half = 40, sc_rbusy = 0, sc_link = 0, sc_die = 0, sc_lpa = 0;
  logic tick_en = 1, mdl_clear = 0;

  logic [15:0] m_ctl, rec_rst, rec_iso, rec_adv, rec_an;
  logic m_in_rst, m_seen_rst, m_dead, m_an;
  int m_left, m_an_rd, m_polls, w_cnt, lat;
  logic [1:0] tdiv;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= tick_en && (tdiv == 2'd3);
    if (mdl_clear) begin
      m_ctl <= 16'h3400; rec_rst <= 0; rec_iso <= 0; rec_adv <= 0; rec_an <= 0;
      m_in_rst <= 0; m_seen_rst <= 0; m_dead <= 0; m_an <= 0;
      m_left <= 0; m_an_rd <= 0; m_polls <= 0; w_cnt <= 0; lat <= 0; mdio_ack <= 0;
    end else if (mdio_ack) begin
      mdio_ack <= 0; lat <= 0;
    end else if (mdio_req && lat < 2) lat <= lat + 1;
    else if (mdio_req) begin
      mdio_ack <= 1;
      mdio_rdata <= 16'hFFFF;
      if (mdio_wr) begin
        w_cnt <= w_cnt + 1;
        if (int'(mdio_phy) == sc_addr) begin
          if (mdio_reg == 5'd4) rec_adv <= mdio_wdata;
          else if (mdio_reg == 5'd0) begin
            if (mdio_wdata[15] && !m_seen_rst) begin
              rec_rst <= mdio_wdata; m_seen_rst <= 1; m_in_rst <= 1;
              m_left <= sc_rbusy; m_ctl <= mdio_wdata & 16'h7FFF;
              if (sc_die != 0) m_dead <= 1;
            end else if (mdio_wdata == 16'h1200) begin rec_an <= mdio_wdata; m_an <= 1; end
            else begin rec_iso <= mdio_wdata; m_ctl <= mdio_wdata; end
          end
        end
      end else if (int'(mdio_phy) == sc_addr) begin
        if (mdio_reg == 5'd0) begin
          if (m_in_rst) m_polls <= m_polls + 1;
          if (m_dead) mdio_rdata <= 16'hFFFF;
          else if (m_in_rst && m_left > 0) begin mdio_rdata <= m_ctl | 16'h8000; m_left <= m_left - 1; end
          else begin mdio_rdata <= m_ctl; m_in_rst <= 0; end
        end else if (mdio_reg == 5'd1) begin
          if (!m_an) mdio_rdata <= 16'h7809;
          else begin
            mdio_rdata <= ((m_an_rd / 2) >= sc_link) ?
              (16'h7809 | ((m_an_rd % 2) != 0 ? 16'h0020 : 16'h0004)) : 16'h7809;
            m_an_rd <= m_an_rd + 1;
          end
        end else if (mdio_reg == 5'd5) mdio_rdata <= 16'(sc_lpa);
        else mdio_rdata <= 16'h0000;
      end else if (int'(mdio_phy) == sc_half) begin
        mdio_rdata <= (mdio_reg == 5'd0) ? 16'h1000 : 16'hFFFF;
      end
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run_seq(input bit do_start);
    mdl_clear = 1; @(negedge clk); mdl_clear = 0;
    if (do_start) begin start = 1; @(negedge clk); start = 0; end
  endtask

  task automatic wait_done(input string rq);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (!done) chk({rq, " watchdog"}, 0, 1);
  endtask

  initial begin
    tdiv = 0;
    mdl_clear = 1;
    repeat (3) @(negedge clk);
    chk("R12 reset done", done, 0);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset req", mdio_req, 0);
    chk("R12 reset flags", {fail_nophy, fail_died, rst_timeout, an_timeout}, 0);
    chk("R12 reset words", {bmsr_word, lpa_word}, 0);
    rst_n = 1; mdl_clear = 0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      bit nophy, died, rto, ato, ok;
      sc_addr = VEC[v][0]; sc_half = VEC[v][1]; sc_rbusy = VEC[v][2];
      sc_link = VEC[v][3]; sc_die = VEC[v][4]; sc_lpa = VEC[v][5];
      nophy = (sc_addr == 32);
      died  = !nophy && sc_die != 0;
      rto   = !nophy && !died && sc_rbusy >= RP;
      ato   = !nophy && !died && sc_link >= AP;
      ok    = !nophy && !died && !ato;
      run_seq(1);
      chk("R12 start clears done", done, 0);
      wait_done("R11");
      @(negedge clk);
      chk("R2 nophy flag", fail_nophy, nophy);
      chk("R4 died flag", fail_died, died);
      chk("R5 reset timeout flag", rst_timeout, rto);
      chk("R9 an timeout flag", an_timeout, ato);
      chk("R10 partner word", lpa_word, ok ? sc_lpa : 0);
      if (nophy) chk("R2 no writes", w_cnt, 0);
      else begin
        chk("R1 selected addr", phy_addr, sc_addr);
        chk("R3 reset write", rec_rst, 16'hB400);
      end
      if (died) chk("R4 no advertise after death", rec_adv, 0);
      if (!nophy && !died) begin
        chk("R6 isolate clear", rec_iso, rto ? 16'hB000 : 16'h3000);
        chk("R8 advertise", rec_adv, 16'h01E1);
        chk("R8 autoneg start", rec_an, 16'h1200);
        chk("R7 ored status", bmsr_word, ok ? 16'h782D : 16'h7809);
        if (rto) chk("R5 poll bound", m_polls, RP);
      end
    end

    sc_addr = 0; sc_half = 40; sc_rbusy = 0; sc_link = 0; sc_die = 0; sc_lpa = 16'h0123;
    tick_en = 0;
    run_seq(1);
    begin
      int n = 0;
      while (rec_rst == 0 && n < 2000) begin @(negedge clk); n++; end
    end
    repeat (60) @(negedge clk);
    chk("R4 no poll without tick", m_polls, 0);
    chk("R4 still busy", busy, 1);
    tick_en = 1;
    wait_done("R4");
    @(negedge clk);
    chk("R4 resumes with tick", m_polls, 1);
    chk("R10 partner after stall", lpa_word, 16'h0123);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule